// File: doc/BRIEF.md
# Gate Switching Timeout Monitor

This block checks that the gate of a power switch finishes each switching edge within a bounded time. One counter is shared by both directions. A turn-on starts it when the PWM command rises. A turn-off starts it when a strobe reports the hard transition of a regular or safe turn-off. While the counter runs, it advances on each enable pulse from a slow oscillator domain.

The counter stops as soon as the gate comparator for the current direction reports that the gate has crossed its threshold: the high threshold for turn-on, the low threshold for turn-off. If the counter runs past its full range first, a sticky error flag is set. The flag stays set until a clear pulse. In two operating modes the turn-on check is skipped, and the turn-off check still runs in those modes.

The comparator inputs are asynchronous. Each passes through a two-flop synchronizer before the logic uses it.

Top module: `gate_tmo_mon`

## Requirements
- R1: After reset, `err_o` is low and no timing is in progress.
- R2: In a mode other than 5 and 6, a 0-to-1 change of `pwm_i` clears the counter and starts a turn-on timing. Only `gate_hi_i` stops this timing; `gate_lo_i` has no effect on it. If the 2^CNT_W-th `tick_i` pulse arrives before the stop, `err_o` is set.
- R3: A one-cycle `off_evt_i` strobe clears the counter and starts a turn-off timing in every mode. Only `gate_lo_i` stops it. If the 2^CNT_W-th `tick_i` pulse arrives before the stop, `err_o` is set. A falling `pwm_i` starts nothing.
- R4: If the threshold for the current direction is reached after at most 2^CNT_W-1 ticks, no error is raised, and later ticks have no effect until the next transition.
- R5: When `mode_i` equals 5 or 6, a rising `pwm_i` starts no turn-on timing and can never raise the error.
- R6: A rising `pwm_i` suppressed by R5 also ends a timing that is still running, so later ticks raise no error.
- R7: `err_o` stays high until a cycle with `err_clr_i` high. If a clear and an overflow fall on the same clock edge, `err_o` stays high.
- R8: The counter saturates at overflow and stops. A single transition sets the error at most once, so ticks after a cleared error do not set it again.
- R9: A transition that arrives while a timing is running restarts the counter from zero for the new direction.
- R10: A comparator level is used only after it has passed through SYNC_STAGES flops. If `off_evt_i` and a rising `pwm_i` arrive in the same cycle, the turn-off wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | PWM command; a rising edge starts a turn-on timing |
| off_evt_i | input | 1 | One-cycle strobe at the hard transition of a turn-off |
| gate_hi_i | input | 1 | Asynchronous comparator: gate above the high threshold |
| gate_lo_i | input | 1 | Asynchronous comparator: gate below the low threshold |
| mode_i | input | MODE_W (3) | Operating-mode code |
| tick_i | input | 1 | Count enable from the slow oscillator domain |
| err_clr_i | input | 1 | Synchronous clear of the error flag |
| err_o | output | 1 | Sticky gate-error flag |

## Verification
The bench builds the monitor with CNT_W = 4, so an overflow takes 16 ticks rather than 256. With that setting the exact boundary between 15 and 16 ticks can be tested for both directions and for every mode class within a few hundred cycles. The synchronizer depth and the two skipped mode codes keep their default values, so the tests for mode suppression and for threshold latency match the production configuration.

// File: rtl/gate_tmo_pkg.sv
package gate_tmo_pkg;
  typedef enum logic {DIR_OFF = 1'b0, DIR_ON = 1'b1} sw_dir_e;
endpackage

// File: rtl/gate_tmo_sync.sv
module gate_tmo_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/gate_tmo_timer.sv
module gate_tmo_timer
  import gate_tmo_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  sw_dir_e dir_i,
  input  logic    abort_i,
  input  logic    hit_hi_i,
  input  logic    hit_lo_i,
  input  logic    tick_i,
  output logic    run_o,
  output logic    ovf_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  sw_dir_e          dir_q;
  logic             stop;

  assign stop  = run_q && ((dir_q == DIR_ON) ? hit_hi_i : hit_lo_i);
  assign ovf_o = run_q && !stop && !start_i && !abort_i && tick_i && (cnt_q == CntMax);
  assign run_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      dir_q <= DIR_OFF;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      dir_q <= dir_i;
    end else if (abort_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (stop) begin
        run_q <= 1'b0;
      end else if (tick_i) begin
        if (cnt_q == CntMax) run_q <= 1'b0; // saturate, no wrap
        else                 cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q && cnt_q == '0));

  // R8
  ovf_saturates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (!run_q && cnt_q == CntMax));

  // R4
  count_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/gate_tmo_mon.sv
module gate_tmo_mon
  import gate_tmo_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MODE_W      = 3,
  parameter int unsigned SKIP_MODE_A = 5,
  parameter int unsigned SKIP_MODE_B = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic              off_evt_i,
  input  logic              gate_hi_i,
  input  logic              gate_lo_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              tick_i,
  input  logic              err_clr_i,
  output logic              err_o
);
  localparam logic [MODE_W-1:0] SkipA = MODE_W'(SKIP_MODE_A);
  localparam logic [MODE_W-1:0] SkipB = MODE_W'(SKIP_MODE_B);

  logic [1:0] cmp_sync;
  logic       pwm_q, pwm_rise, skip_on;
  logic       start, abort, ovf, run;
  sw_dir_e    dir;
  logic       err_q;

  gate_tmo_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({gate_hi_i, gate_lo_i}),
    .q_o    (cmp_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_i;
  end

  assign pwm_rise = pwm_i && !pwm_q;
  assign skip_on  = (mode_i == SkipA) || (mode_i == SkipB);
  // turn-off strobe wins over a coincident turn-on
  assign start    = off_evt_i || (pwm_rise && !skip_on);
  assign dir      = off_evt_i ? DIR_OFF : DIR_ON;
  assign abort    = pwm_rise && skip_on && !off_evt_i;

  gate_tmo_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .dir_i    (dir),
    .abort_i  (abort),
    .hit_hi_i (cmp_sync[1]),
    .hit_lo_i (cmp_sync[0]),
    .tick_i   (tick_i),
    .run_o    (run),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (ovf)       err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q);

  // R7
  clr_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && err_clr_i) |=> err_q);

  // R5
  skip_turn_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_rise && skip_on && !off_evt_i) |=> !run);

  // R2
  no_spurious_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && !ovf) |=> !err_q);
endmodule

// File: tb/test_gate_tmo_mon.sv
module test_gate_tmo_mon;
  localparam int CNT_W = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0, off_evt = 1'b0, g_hi = 1'b0, g_lo = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       tick = 1'b0, clr = 1'b0;
  logic       err;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gate_tmo_mon #(.CNT_W(CNT_W)) i_gate_tmo_mon (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .off_evt_i(off_evt),
    .gate_hi_i(g_hi), .gate_lo_i(g_lo), .mode_i(mode), .tick_i(tick),
    .err_clr_i(clr), .err_o(err)
  );

  // {expect, mode[2:0], turn_on, ticks[7:0]}
  localparam int NV = 13;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b1, 8'd5},  {1'b0, 3'd0, 1'b1, 8'd15}, {1'b1, 3'd0, 1'b1, 8'd16},
    {1'b0, 3'd0, 1'b0, 8'd3},  {1'b0, 3'd0, 1'b0, 8'd15}, {1'b1, 3'd0, 1'b0, 8'd16},
    {1'b0, 3'd5, 1'b1, 8'd20}, {1'b0, 3'd6, 1'b1, 8'd20}, {1'b1, 3'd5, 1'b0, 8'd16},
    {1'b0, 3'd6, 1'b0, 8'd15}, {1'b1, 3'd6, 1'b0, 8'd16}, {1'b1, 3'd4, 1'b1, 8'd16},
    {1'b1, 3'd7, 1'b1, 8'd16}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (err !== exp) begin
      n_bad++;
      $display("FAIL %s: err_o=%b expected %b", req, err, exp);
    end
  endtask

  task automatic prep(input logic [2:0] m, input logic p);
    tick = 0; clr = 1; g_hi = 0; g_lo = 0; mode = m; pwm = p;
    step(1);
    clr = 0;
    step(3);
  endtask

  task automatic run_vec(input logic [12:0] v);
    logic       ex = v[12];
    logic [2:0] m  = v[11:9];
    logic       on = v[8];
    int         nt = int'(v[7:0]);
    prep(m, on ? 1'b0 : 1'b1);
    if (on) pwm = 1; else begin off_evt = 1; pwm = 0; end
    step(1);
    off_evt = 0; tick = 1;
    step(nt);
    tick = 0;
    if (on) g_hi = 1; else g_lo = 1;
    step(4);
    tick = 1;
    step(40);
    tick = 0;
    if (m == 3'd5 || m == 3'd6) check(on ? "R5" : "R5 turn-off still checked", ex);
    else if (!ex)               check("R4", ex);
    else                        check(on ? "R2" : "R3", ex);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2);
    check("R1", 1'b0);
    rst_n = 1;
    step(2);
    check("R1", 1'b0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R7 sticky, then clear
    step(10);
    check("R7 sticky", 1'b1);
    clr = 1; step(1); clr = 0; step(1);
    check("R7 clear", 1'b0);

    // R7 clear coincident with overflow
    prep(3'd0, 1'b0);
    pwm = 1; step(1);
    tick = 1; step(15);
    clr = 1; step(1);
    clr = 0; tick = 0; step(1);
    check("R7 clear+overflow", 1'b1);

    // R8 no second error from same transition
    clr = 1; step(1); clr = 0;
    tick = 1; step(50); tick = 0;
    check("R8", 1'b0);

    // R9 restart on new direction
    prep(3'd0, 1'b0);
    pwm = 1; step(1);
    tick = 1; step(10);
    tick = 0; off_evt = 1; pwm = 0; step(1);
    off_evt = 0; tick = 1; step(10);
    check("R9 restart", 1'b0);
    step(6); tick = 0;
    check("R9 overflow after restart", 1'b1);

    // R6 suppressed turn-on ends a running turn-off
    prep(3'd5, 1'b0);
    off_evt = 1; step(1);
    off_evt = 0; tick = 1; step(10);
    tick = 0; pwm = 1; step(1);
    tick = 1; step(30); tick = 0;
    check("R6", 1'b0);

    // R2 low comparator does not stop a turn-on
    prep(3'd0, 1'b0);
    pwm = 1; step(1);
    tick = 1; step(5); tick = 0;
    g_lo = 1; step(4);
    tick = 1; step(20); tick = 0;
    check("R2 wrong threshold ignored", 1'b1);

    // R10 coincident off strobe and pwm rise: off wins, gate_hi has no effect
    prep(3'd0, 1'b0);
    pwm = 1; off_evt = 1; step(1);
    off_evt = 0; g_hi = 1; step(4);
    tick = 1; step(20); tick = 0;
    check("R10 turn-off priority", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule